// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block chooses how a small processor core enters a handler when an event is pending. It watches three request sources at once: a synchronous exception (with a cause code and an optional faulting address), a debug request, and the already resolved highest pending interrupt level. It also takes the pending and enable masks of the interrupt lines. On the clock edge where it accepts an event it updates the special registers it owns: the status word, the per-level saved PC and saved status, the exception cause, the faulting address, the double-exception PC and the debug cause. In the same edge it emits the handler address and a one-cycle taken strobe.

Level-1 interrupts and general exceptions share one entry path. That path picks the user, kernel or double-exception vector from the status bits. Levels 2 and above, the non-maskable level and the debug level save their state into the registers of that level and run with the status interrupt level raised to it. A wait input lowers or raises the status interrupt level and holds the core halted until an interrupt can be accepted. The core can also load the status word directly, for example on return from a handler.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word, all saved registers, cause, faulting address, double PC, debug cause, next PC, irq_clr, taken and halt are all zero.
- R2: An exception taken while status bit 4 (exception mode) is clear saves cur_pc in the level-1 saved PC. It writes exc_cause into the cause register and sets status bit 4. It jumps to the user vector when status bit 5 (user mode) is set and to the kernel vector otherwise. taken is high for that single cycle only.
- R3: A general entry taken while status bit 4 is already set writes cur_pc into the double PC, leaves the level-1 saved PC unchanged and jumps to the double-exception vector.
- R4: The faulting address register is loaded from exc_vaddr only when exc_has_addr accompanies the exception. Otherwise it keeps its value.
- R5: A pending level L in 1..NUM_LEVELS (default 6) is accepted only when L exceeds status bits 3:0 and some line mapped to L (lines 0 and 1 map to level 1, line i to level i for i = 2..7) is both pending and enabled. A rejected level changes nothing.
- R6: An accepted level-1 interrupt is a general entry with cause code 4. It follows the same user, kernel or double selection and leaves status bits 3:0 unchanged.
- R7: An accepted level L of 2 or more saves cur_pc and the old status in the level-L save registers. It sets status bits 3:0 to L with bit 4 set and jumps to the level-L vector.
- R8: The non-maskable level 7 is accepted whatever the masks and the current level, and for that cycle irq_clr pulses the mask of the lines mapped to level 7 (8'h80).
- R9: A debug request is taken only when status bits 3:0 are below the debug level (6). It writes dbg_cause into the debug cause, saves PC and status in the level-6 registers, sets the status level to 6 with bit 4 set and jumps to the level-6 vector. Otherwise it is ignored.
- R10: Targets are vecbase plus an offset: kernel 0x300, user 0x340, double 0x3C0, and level L at 0x180 + (L-2)*0x40.
- R11: wait_req with no entry loads status bits 3:0 from wait_level and raises halt. halt stays high until the next entry, which lowers it on the same edge.
- R12: Sources are prioritised exception, then debug, then interrupt, then wait, then status write.
- R13: status_wr with no higher source loads the status word from status_wdata (bits 3:0 level, bit 4 exception mode, bit 5 user mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| vecbase | input | 32 | Current vector base |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 6 | Exception cause code |
| exc_has_addr | input | 1 | Exception carries a faulting address |
| exc_vaddr | input | 32 | Faulting virtual address |
| dbg_req | input | 1 | Debug event request |
| dbg_cause | input | 6 | Debug cause value |
| irq_level | input | 4 | Resolved pending interrupt level (0 = none) |
| irq_pend | input | 8 | Pending interrupt lines |
| irq_en | input | 8 | Enabled interrupt lines |
| wait_req | input | 1 | Wait-for-interrupt request |
| wait_level | input | 4 | Interrupt level loaded by the wait |
| status_wr | input | 1 | Direct status load |
| status_wdata | input | 6 | Status value to load |
| status | output | 6 | Status word |
| save_pc | output | 224 | Saved PCs, level L at bits (L-1)*32 upward |
| save_status | output | 42 | Saved status words, level L at bits (L-1)*6 upward |
| exc_cause_r | output | 6 | Exception cause register |
| fault_addr | output | 32 | Faulting address register |
| dbl_pc | output | 32 | Double-exception PC |
| dbg_cause_r | output | 6 | Debug cause register |
| next_pc | output | 32 | Handler address of the last entry |
| taken | output | 1 | One-cycle entry strobe |
| halt | output | 1 | Core stalled by a wait |
| irq_clr | output | 8 | One-cycle clear mask for non-maskable lines |

## Verification
Every result is a register, so it appears at the first rising edge after the inputs are presented: the status word, the saved registers, next_pc, taken, halt and irq_clr are all due one cycle after the request. The driver presents the inputs shortly after a rising edge. It computes the expected register image from the requirements and queues it at the next rising edge. The monitor compares it at the falling edge that follows, so each comparison lands half a cycle after the result is due. Holding inputs idle between requests shows that taken and irq_clr fall back after one cycle and that rejected requests leave the state alone.

// File: rtl/exc_pkg.sv
package exc_pkg;
    // status word layout
    localparam int PSW      = 6;
    localparam int IL_LSB   = 0;
    localparam int IL_W     = 4;
    localparam int EXCM_BIT = 4;
    localparam int UM_BIT   = 5;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_GEN,
        ENT_HIGH,
        ENT_DBG
    } entry_kind_e;
endpackage

// File: rtl/exc_irq_accept.sv
module exc_irq_accept #(
    parameter int                          NIRQ       = 8,
    parameter int                          LW         = 4,
    parameter int                          NUM_LEVELS = 6,
    parameter int                          NMI_LEVEL  = 7,
    parameter logic [NIRQ*LW-1:0]          IRQ_LEVELS = 32'h7654_3211
) (
    input  logic [LW-1:0]   lvl,
    input  logic [LW-1:0]   cur_il,
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] en,
    output logic            ok,
    output logic [NIRQ-1:0] nmi_mask
);
    localparam logic [LW-1:0] NMI_L = LW'(NMI_LEVEL);
    localparam logic [LW-1:0] TOP_L = LW'(NUM_LEVELS);

    logic [NIRQ-1:0] lvl_sel;

    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        assign lvl_sel[g]  = (IRQ_LEVELS[g*LW +: LW] == lvl);
        assign nmi_mask[g] = (IRQ_LEVELS[g*LW +: LW] == NMI_L);
    end

    // R5 / R8: masked levels need priority and a live line, the NMI level does not
    assign ok = ((lvl > cur_il) && (lvl <= TOP_L) && (|(lvl_sel & pend & en)))
              || (lvl == NMI_L);
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_pkg::*;
#(
    parameter int               XLEN         = 32,
    parameter int               LW           = 4,
    parameter bit               RELOC        = 1'b1,
    parameter logic [XLEN-1:0]  DEF_VECBASE  = 32'h4000_0000,
    parameter logic [XLEN-1:0]  OFS_KERNEL   = 32'h300,
    parameter logic [XLEN-1:0]  OFS_USER     = 32'h340,
    parameter logic [XLEN-1:0]  OFS_DOUBLE   = 32'h3C0,
    parameter logic [XLEN-1:0]  OFS_LVL_BASE = 32'h180,
    parameter logic [XLEN-1:0]  OFS_LVL_STEP = 32'h40
) (
    input  entry_kind_e      kind,
    input  logic [LW-1:0]    lvl,
    input  logic             excm,
    input  logic             um,
    input  logic [XLEN-1:0]  vecbase,
    output logic [XLEN-1:0]  target
);
    logic [XLEN-1:0] ofs;
    logic [XLEN-1:0] def_vec;

    always_comb begin
        unique case (kind)
            ENT_GEN:          ofs = excm ? OFS_DOUBLE : (um ? OFS_USER : OFS_KERNEL);
            ENT_HIGH, ENT_DBG: ofs = OFS_LVL_BASE + XLEN'(lvl - LW'(2)) * OFS_LVL_STEP;
            default:          ofs = '0;
        endcase
        def_vec = DEF_VECBASE + ofs;
    end

    // R10: relocated vectors move with the live vector base
    if (RELOC) begin : g_reloc
        assign target = def_vec - DEF_VECBASE + vecbase;
    end else begin : g_fixed
        logic unused_base;
        assign unused_base = ^vecbase;
        assign target = def_vec;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                  XLEN        = 32,
    parameter int                  CW          = 6,
    parameter int                  NIRQ        = 8,
    parameter int                  NUM_LEVELS  = 6,
    parameter int                  NMI_LEVEL   = 7,
    parameter int                  DEBUG_LEVEL = 6,
    parameter bit                  HAS_DEPC    = 1'b1,
    parameter bit                  RELOC       = 1'b1,
    parameter int                  L1_CAUSE    = 4,
    parameter logic [NIRQ*4-1:0]   IRQ_LEVELS  = 32'h7654_3211,
    parameter logic [XLEN-1:0]     DEF_VECBASE = 32'h4000_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [XLEN-1:0]           cur_pc,
    input  logic [XLEN-1:0]           vecbase,
    input  logic                      exc_req,
    input  logic [CW-1:0]             exc_cause,
    input  logic                      exc_has_addr,
    input  logic [XLEN-1:0]           exc_vaddr,
    input  logic                      dbg_req,
    input  logic [CW-1:0]             dbg_cause,
    input  logic [3:0]                irq_level,
    input  logic [NIRQ-1:0]           irq_pend,
    input  logic [NIRQ-1:0]           irq_en,
    input  logic                      wait_req,
    input  logic [3:0]                wait_level,
    input  logic                      status_wr,
    input  logic [5:0]                status_wdata,
    output logic [5:0]                status,
    output logic [NMI_LEVEL*XLEN-1:0] save_pc,
    output logic [NMI_LEVEL*6-1:0]    save_status,
    output logic [CW-1:0]             exc_cause_r,
    output logic [XLEN-1:0]           fault_addr,
    output logic [XLEN-1:0]           dbl_pc,
    output logic [CW-1:0]             dbg_cause_r,
    output logic [XLEN-1:0]           next_pc,
    output logic                      taken,
    output logic                      halt,
    output logic [NIRQ-1:0]           irq_clr
);
    localparam int            LW    = IL_W;
    localparam int            NLVL  = NMI_LEVEL;
    localparam logic [LW-1:0] DBG_L = LW'(DEBUG_LEVEL);
    localparam logic [LW-1:0] NMI_L = LW'(NMI_LEVEL);
    localparam logic [LW-1:0] ONE_L = LW'(1);

    typedef struct packed {
        logic [PSW-1:0]             ps;
        logic [NLVL:1][XLEN-1:0]    spc;
        logic [NLVL:1][PSW-1:0]     sps;
        logic [CW-1:0]              cause;
        logic [XLEN-1:0]            vaddr;
        logic [XLEN-1:0]            depc;
        logic [CW-1:0]              dcause;
        logic [XLEN-1:0]            npc;
        logic                       taken;
        logic                       halt;
        logic [NIRQ-1:0]            iclr;
    } state_t;

    state_t          state_d, state_q;
    entry_kind_e     kind;
    logic [LW-1:0]   sel_lvl;
    logic [CW-1:0]   gen_cause;
    logic            irq_ok;
    logic [NIRQ-1:0] nmi_mask;
    logic [XLEN-1:0] vec;
    logic [LW-1:0]   cur_il;
    logic            cur_excm;

    assign cur_il   = state_q.ps[IL_LSB +: IL_W];
    assign cur_excm = state_q.ps[EXCM_BIT];

    exc_irq_accept #(
        .NIRQ(NIRQ), .LW(LW), .NUM_LEVELS(NUM_LEVELS),
        .NMI_LEVEL(NMI_LEVEL), .IRQ_LEVELS(IRQ_LEVELS)
    ) accept_i (
        .lvl(irq_level), .cur_il(cur_il), .pend(irq_pend), .en(irq_en),
        .ok(irq_ok), .nmi_mask(nmi_mask)
    );

    // R12: exception over debug over interrupt
    always_comb begin
        kind      = ENT_NONE;
        sel_lvl   = '0;
        gen_cause = '0;
        if (exc_req) begin
            kind      = ENT_GEN;
            gen_cause = exc_cause;
        end else if (dbg_req && (cur_il < DBG_L)) begin
            kind    = ENT_DBG;
            sel_lvl = DBG_L;
        end else if (irq_ok) begin
            if (irq_level == ONE_L) begin
                kind      = ENT_GEN;
                gen_cause = CW'(L1_CAUSE);
            end else begin
                kind    = ENT_HIGH;
                sel_lvl = irq_level;
            end
        end
    end

    exc_vec_sel #(
        .XLEN(XLEN), .LW(LW), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE)
    ) vec_i (
        .kind(kind), .lvl(sel_lvl), .excm(cur_excm),
        .um(state_q.ps[UM_BIT]), .vecbase(vecbase), .target(vec)
    );

    always_comb begin
        state_d       = state_q;
        state_d.taken = 1'b0;
        state_d.iclr  = '0;
        unique case (kind)
            ENT_GEN: begin
                // R2 / R3 / R6
                if (cur_excm && HAS_DEPC) state_d.depc = cur_pc;
                else                      state_d.spc[1] = cur_pc;
                state_d.cause            = gen_cause;
                // R4
                if (exc_req && exc_has_addr) state_d.vaddr = exc_vaddr;
                state_d.ps[EXCM_BIT]     = 1'b1;
                state_d.npc              = vec;
                state_d.taken            = 1'b1;
                state_d.halt             = 1'b0;
            end
            ENT_HIGH, ENT_DBG: begin
                // R7 / R9
                state_d.spc[sel_lvl]            = cur_pc;
                state_d.sps[sel_lvl]            = state_q.ps;
                state_d.ps[IL_LSB +: IL_W]      = sel_lvl;
                state_d.ps[EXCM_BIT]            = 1'b1;
                if (kind == ENT_DBG) state_d.dcause = dbg_cause;
                // R8
                if (sel_lvl == NMI_L) state_d.iclr = nmi_mask;
                state_d.npc   = vec;
                state_d.taken = 1'b1;
                state_d.halt  = 1'b0;
            end
            default: begin
                if (wait_req) begin
                    // R11
                    state_d.ps[IL_LSB +: IL_W] = wait_level;
                    state_d.halt               = 1'b1;
                end else if (status_wr) begin
                    // R13
                    state_d.ps = status_wdata;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;   // R1
        else        state_q <= state_d;
    end

    assign status      = state_q.ps;
    assign save_pc     = state_q.spc;
    assign save_status = state_q.sps;
    assign exc_cause_r = state_q.cause;
    assign fault_addr  = state_q.vaddr;
    assign dbl_pc      = state_q.depc;
    assign dbg_cause_r = state_q.dcause;
    assign next_pc     = state_q.npc;
    assign taken       = state_q.taken;
    assign halt        = state_q.halt;
    assign irq_clr     = state_q.iclr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int CW        = 6,
    parameter int NIRQ      = 8,
    parameter int NMI_LEVEL = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic [CW-1:0]   exc_cause,
    input logic [3:0]      wait_level,
    input logic            taken,
    input logic [5:0]      status,
    input logic            halt,
    input logic [NIRQ-1:0] irq_clr,
    input logic [CW-1:0]   exc_cause_r
);
    localparam logic [3:0] NMI_L = 4'(NMI_LEVEL);

    // R2
    entry_sets_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> status[4]);

    // R2
    exc_taken_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_req) |-> (taken && exc_cause_r == $past(exc_cause)));

    // R11
    entry_releases_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> !halt);

    // R11
    wait_loads_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> status[3:0] == $past(wait_level));

    // R8
    nmi_clear_only_on_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_clr) |-> (taken && status[3:0] == NMI_L));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .CW(CW), .NIRQ(NIRQ), .NMI_LEVEL(NMI_LEVEL)
) chk_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .wait_level(wait_level), .taken(taken), .status(status), .halt(halt),
    .irq_clr(irq_clr), .exc_cause_r(exc_cause_r)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cur_pc, vecbase, exc_vaddr;
    logic         exc_req, exc_has_addr, dbg_req, wait_req, status_wr;
    logic [5:0]   exc_cause, dbg_cause, status_wdata;
    logic [3:0]   irq_level, wait_level;
    logic [7:0]   irq_pend, irq_en;
    logic [5:0]   status, exc_cause_r, dbg_cause_r;
    logic [223:0] save_pc;
    logic [41:0]  save_status;
    logic [31:0]  fault_addr, dbl_pc, next_pc;
    logic         taken, halt;
    logic [7:0]   irq_clr;

    always #2 clk = ~clk;   // 250 MHz

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .vecbase(vecbase),
        .exc_req(exc_req), .exc_cause(exc_cause), .exc_has_addr(exc_has_addr),
        .exc_vaddr(exc_vaddr), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
        .irq_level(irq_level), .irq_pend(irq_pend), .irq_en(irq_en),
        .wait_req(wait_req), .wait_level(wait_level), .status_wr(status_wr),
        .status_wdata(status_wdata), .status(status), .save_pc(save_pc),
        .save_status(save_status), .exc_cause_r(exc_cause_r),
        .fault_addr(fault_addr), .dbl_pc(dbl_pc), .dbg_cause_r(dbg_cause_r),
        .next_pc(next_pc), .taken(taken), .halt(halt), .irq_clr(irq_clr)
    );

    typedef struct {
        string        req;
        logic [5:0]   ps;
        logic [223:0] spc;
        logic [41:0]  sps;
        logic [5:0]   cause, dcause;
        logic [31:0]  vaddr, depc, npc;
        logic         taken, halt;
        logic [7:0]   iclr;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;

    // bench model of the architectural registers
    logic [5:0]  m_ps, m_cause, m_dcause;
    logic [31:0] m_spc [1:7];
    logic [5:0]  m_sps [1:7];
    logic [31:0] m_vaddr, m_depc, m_npc;
    logic        m_taken, m_halt;
    logic [7:0]  m_clr;

    function automatic logic [3:0] line_level(int i);
        return (i < 2) ? 4'd1 : 4'(i);
    endfunction

    task automatic idle();
        exc_req = 0; exc_cause = 0; exc_has_addr = 0; exc_vaddr = 0;
        dbg_req = 0; dbg_cause = 0; irq_level = 0; irq_pend = 0; irq_en = 0;
        wait_req = 0; wait_level = 0; status_wr = 0; status_wdata = 0;
    endtask

    task automatic enter_general(input logic [5:0] c);
        logic um;
        um = m_ps[5];
        if (m_ps[4]) begin
            m_depc = cur_pc;
            m_npc  = vecbase + 32'h3C0;
        end else begin
            m_spc[1] = cur_pc;
            m_npc    = vecbase + (um ? 32'h340 : 32'h300);
        end
        m_cause = c;
        m_ps[4] = 1'b1;
        m_taken = 1'b1;
        m_halt  = 1'b0;
    endtask

    task automatic enter_level(input logic [3:0] l);
        m_spc[l] = cur_pc;
        m_sps[l] = m_ps;
        m_ps     = {m_ps[5], 1'b1, l};
        m_npc    = vecbase + 32'h180 + (32'(l) - 32'd2) * 32'h40;
        if (l == 4'd7) m_clr = 8'h80;
        m_taken  = 1'b1;
        m_halt   = 1'b0;
    endtask

    task automatic apply(input string req);
        exp_t e;
        logic [7:0] lmask;
        logic ok;
        lmask = '0;
        for (int i = 0; i < 8; i++) if (line_level(i) == irq_level) lmask[i] = 1'b1;
        ok = ((irq_level > m_ps[3:0]) && (irq_level <= 4'd6) && (|(lmask & irq_pend & irq_en)))
           || (irq_level == 4'd7);
        m_taken = 0;
        m_clr   = 0;
        if (exc_req) begin
            if (exc_has_addr) m_vaddr = exc_vaddr;
            enter_general(exc_cause);
        end else if (dbg_req && m_ps[3:0] < 4'd6) begin
            m_dcause = dbg_cause;
            enter_level(4'd6);
        end else if (ok) begin
            if (irq_level == 4'd1) enter_general(6'd4);
            else                   enter_level(irq_level);
        end else if (wait_req) begin
            m_ps[3:0] = wait_level;
            m_halt    = 1'b1;
        end else if (status_wr) begin
            m_ps = status_wdata;
        end
        e.req = req; e.ps = m_ps; e.cause = m_cause; e.dcause = m_dcause;
        e.vaddr = m_vaddr; e.depc = m_depc; e.npc = m_npc;
        e.taken = m_taken; e.halt = m_halt; e.iclr = m_clr;
        for (int l = 1; l <= 7; l++) begin
            e.spc[(l-1)*32 +: 32] = m_spc[l];
            e.sps[(l-1)*6 +: 6]   = m_sps[l];
        end
        @(posedge clk);
        sb.push_back(e);
        #1 idle();
    endtask

    task automatic set_status(input logic [5:0] v, input string req);
        status_wr = 1; status_wdata = v;
        apply(req);
    endtask

    // monitor: result is registered on the edge the item was queued, compare half a cycle later
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            bad = 0;
            n_chk++;
            if (status !== e.ps) begin bad = 1; $display("FAIL %s status act=%h exp=%h", e.req, status, e.ps); end
            if (save_pc !== e.spc) begin bad = 1; $display("FAIL %s save_pc act=%h exp=%h", e.req, save_pc, e.spc); end
            if (save_status !== e.sps) begin bad = 1; $display("FAIL %s save_status act=%h exp=%h", e.req, save_status, e.sps); end
            if (exc_cause_r !== e.cause) begin bad = 1; $display("FAIL %s cause act=%h exp=%h", e.req, exc_cause_r, e.cause); end
            if (dbg_cause_r !== e.dcause) begin bad = 1; $display("FAIL %s dbg_cause act=%h exp=%h", e.req, dbg_cause_r, e.dcause); end
            if (fault_addr !== e.vaddr) begin bad = 1; $display("FAIL %s fault_addr act=%h exp=%h", e.req, fault_addr, e.vaddr); end
            if (dbl_pc !== e.depc) begin bad = 1; $display("FAIL %s dbl_pc act=%h exp=%h", e.req, dbl_pc, e.depc); end
            if (next_pc !== e.npc) begin bad = 1; $display("FAIL %s next_pc act=%h exp=%h", e.req, next_pc, e.npc); end
            if (taken !== e.taken) begin bad = 1; $display("FAIL %s taken act=%b exp=%b", e.req, taken, e.taken); end
            if (halt !== e.halt) begin bad = 1; $display("FAIL %s halt act=%b exp=%b", e.req, halt, e.halt); end
            if (irq_clr !== e.iclr) begin bad = 1; $display("FAIL %s irq_clr act=%h exp=%h", e.req, irq_clr, e.iclr); end
            if (bad) n_bad++;
        end
    end

    initial begin
        #40000;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        cur_pc = 0; vecbase = 32'h8000_0000;
        m_ps = 0; m_cause = 0; m_dcause = 0; m_vaddr = 0; m_depc = 0; m_npc = 0;
        m_taken = 0; m_halt = 0; m_clr = 0;
        for (int l = 1; l <= 7; l++) begin m_spc[l] = 0; m_sps[l] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        apply("R1");                                             // reset image
        // R2 R4 R10: kernel entry with faulting address
        cur_pc = 32'h100; exc_req = 1; exc_cause = 6'd7; exc_has_addr = 1; exc_vaddr = 32'hDEAD_0000;
        apply("R2");
        apply("R2");                                             // strobe gone
        // R3 R4: exception in exception mode, no address
        cur_pc = 32'h200; exc_req = 1; exc_cause = 6'd9; exc_vaddr = 32'h1111_1111;
        apply("R3");
        set_status(6'h20, "R13");
        cur_pc = 32'h300; exc_req = 1; exc_cause = 6'd3;
        apply("R2");                                             // user vector
        set_status(6'h02, "R13");
        // R5: level not above current, then line disabled
        cur_pc = 32'h400; irq_level = 2; irq_pend = 8'h04; irq_en = 8'h04;
        apply("R5");
        irq_level = 3; irq_pend = 8'h08; irq_en = 8'h00;
        apply("R5");
        irq_level = 3; irq_pend = 8'h08; irq_en = 8'h08;
        apply("R7");
        set_status(6'h00, "R13");
        cur_pc = 32'h500; irq_level = 1; irq_pend = 8'h02; irq_en = 8'h02;
        apply("R6");
        set_status(6'h10, "R13");
        cur_pc = 32'h600; irq_level = 1; irq_pend = 8'h01; irq_en = 8'h01;
        apply("R6");                                             // double path
        set_status(6'h06, "R13");
        cur_pc = 32'h700; dbg_req = 1; dbg_cause = 6'd2;
        apply("R9");                                             // ignored at level 6
        cur_pc = 32'h800; irq_level = 7;
        apply("R8");                                             // NMI without masks
        apply("R8");
        set_status(6'h03, "R13");
        cur_pc = 32'h900; dbg_req = 1; dbg_cause = 6'd5;
        apply("R9");
        set_status(6'h00, "R13");
        cur_pc = 32'hA00; exc_req = 1; exc_cause = 6'd11; dbg_req = 1; dbg_cause = 6'd1;
        irq_level = 2; irq_pend = 8'h04; irq_en = 8'h04; wait_req = 1;
        apply("R12");
        set_status(6'h00, "R13");
        cur_pc = 32'hB00; dbg_req = 1; dbg_cause = 6'd6; irq_level = 2; irq_pend = 8'h04; irq_en = 8'h04;
        apply("R12");
        set_status(6'h00, "R13");
        wait_req = 1; wait_level = 4'd5; status_wr = 1; status_wdata = 6'h3F;
        apply("R11");
        irq_level = 3; irq_pend = 8'h08; irq_en = 8'h08;
        apply("R11");                                            // still halted
        cur_pc = 32'hC00; irq_level = 6; irq_pend = 8'h40; irq_en = 8'h40;
        apply("R11");
        set_status(6'h00, "R13");
        vecbase = 32'h1234_0000; cur_pc = 32'hD00; exc_req = 1; exc_cause = 6'd1;
        apply("R10");
        apply("R1");

        @(negedge clk); @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule